// File: doc/BRIEF.md
# Branch Trace Synchronization Controller

This block sits beside a processor's retirement stage and decides, for every taken direct or indirect branch, whether the trace message it produces may be a plain relative branch record or must carry full synchronization. It counts the instructions retired since the last branch record that was handed downstream. It also keeps a single sticky "sync pending" flag that several independent conditions can raise.

Each qualifying branch produces one request on a valid/ready output. The request carries a sync flag, the instruction count and the branch target. Queueing, packet formatting, pin output and address compression are left to the blocks downstream.

The conditions that raise the flag are:
- reset;
- trace being switched on;
- leaving low-power or debug mode;
- an enabled external event;
- a long run of sequential instructions;
- a fixed number of accepted messages;
- a branch into a secure region;
- a branch whose message could not be issued.

Top module: `branch_sync_ctrl`

## Requirements
- R1: While reset is applied `req_valid` is 0, and the first taken branch after reset with trace enabled yields a request with `req_sync` = 1.
- R2: With no sync cause pending, a taken branch yields a request one cycle later with `req_sync` = 0, `req_addr` equal to the branch target, and `req_count` equal to the number of instructions retired since the last issued request, counting the branch itself.
- R3: While `trace_en` is 0, no new request is issued and retired instructions are not counted. The first branch after `trace_en` rises is sent with sync.
- R4: After `lowpwr_dbg` falls, the next issued branch request carries sync.
- R5: An `evt_in` pulse while `evt_en` = 1 and trace is enabled makes the next issued request carry sync. With `evt_en` = 0 the pulse has no effect.
- R6: A branch with `branch_secure` = 1 issues no request and is itself counted. The next branch is sent with sync.
- R7: A branch that arrives while an earlier request is still waiting (`req_valid` = 1 and `req_ready` = 0) is lost. The next branch is sent with sync, and its count includes the lost branch.
- R8: The instruction counter never reaches 255. The 255th non-messaged instruction clears it and forces sync, so the next branch has count 1 with sync. After exactly 254 plain instructions, the branch has count 255 without sync.
- R9: Once 255 requests have been accepted since reset, the next request carries sync. The 255th request itself is plain.
- R10: The pending flag clears only when a request with `req_sync` = 1 is accepted. A cause that arrives while such a request is waiting survives the acceptance and forces sync on the following branch.
- R11: While `req_valid` = 1 and `req_ready` = 0, the request and all of its fields stay unchanged, and `req_count` is never 0 while valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the trace logic |
| trace_en | input | 1 | Program trace enable |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_branch | input | 1 | The retiring instruction is a taken direct or indirect branch |
| branch_target | input | 32 | Target address of the retiring branch |
| branch_secure | input | 1 | Branch target lies in a secure region |
| lowpwr_dbg | input | 1 | Core is in low-power or debug mode |
| evt_in | input | 1 | External event input |
| evt_en | input | 1 | Allows `evt_in` to request sync |
| req_valid | output | 1 | Branch message request valid |
| req_ready | input | 1 | Downstream accepts the request |
| req_sync | output | 1 | Request is a branch-with-sync message |
| req_count | output | 8 | Instructions since the last issued request, including this branch |
| req_addr | output | 32 | Branch target address |

## Verification
The assertions watch the output handshake on every cycle:
- a new request appears only if trace was enabled in the cycle before;
- a request never follows a secure branch;
- a waiting request holds its fields;
- a valid count is never zero.

Which request carries sync, and with what count, depends on histories spanning hundreds of cycles. That covers the 254 versus 255 instruction boundary, the 255th accepted message, a lost branch folded into the next count, and a cause arriving while a sync request waits. These are shown only by the directed scenarios, which compare every request against hand-derived sync flags and counts.

// File: rtl/branch_sync_ctrl.sv
module branch_sync_ctrl #(
  parameter int CW = 8,
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trace_en,
  input  logic          ret_valid,
  input  logic          ret_branch,
  input  logic [AW-1:0] branch_target,
  input  logic          branch_secure,
  input  logic          lowpwr_dbg,
  input  logic          evt_in,
  input  logic          evt_en,
  output logic          req_valid,
  input  logic          req_ready,
  output logic          req_sync,
  output logic [CW-1:0] req_count,
  output logic [AW-1:0] req_addr
);
  localparam logic [CW-1:0] LAST = {{(CW-1){1'b1}}, 1'b0};

  logic          en_q, lp_q, pend, late;
  logic [CW-1:0] scnt, mcnt;

  wire is_br    = ret_valid & ret_branch & trace_en;
  wire busy     = req_valid & ~req_ready;
  wire acc      = req_valid & req_ready;
  wire issue    = is_br & ~branch_secure & ~busy;
  wire sec_hit  = is_br & branch_secure;
  wire lost     = is_br & ~branch_secure & busy;
  wire bump     = ret_valid & trace_en & ~issue;
  wire ovf      = bump & (scnt == LAST);
  wire per_hit  = acc & (mcnt == LAST);
  wire en_rise  = trace_en & ~en_q;
  wire lp_exit  = lp_q & ~lowpwr_dbg;
  wire evt      = evt_in & evt_en & trace_en;
  wire trig     = en_rise | lp_exit | evt | sec_hit | lost | ovf | per_hit;
  wire acc_sync = acc & req_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      lp_q <= 1'b0;
    end else begin
      en_q <= trace_en;
      lp_q <= lowpwr_dbg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          scnt <= '0;
    else if (!trace_en)  scnt <= '0;
    else if (issue)      scnt <= '0;
    else if (ovf)        scnt <= '0;
    else if (bump)       scnt <= scnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mcnt <= '0;
    else if (per_hit) mcnt <= '0;
    else if (acc)     mcnt <= mcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b1;
      late <= 1'b0;
    end else begin
      if (acc_sync)  pend <= issue | late | trig;
      else if (trig) pend <= 1'b1;
      if (issue | acc) late <= 1'b0;
      else if (req_valid & trig) late <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_sync  <= 1'b0;
      req_count <= '0;
      req_addr  <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_sync  <= pend | trig;
      req_count <= scnt + 1'b1;
      req_addr  <= branch_target;
    end else if (req_ready) begin
      req_valid <= 1'b0;
    end
  end
endmodule

module branch_sync_ctrl_chk #(
  parameter int CW = 8,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          trace_en,
  input logic          branch_secure,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_sync,
  input logic [CW-1:0] req_count,
  input logic [AW-1:0] req_addr
);
  assert_issue_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(trace_en));

  assert_no_secure_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> !$past(branch_secure));

  assert_hold_while_stalled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_sync) &&
                                   $stable(req_count) && $stable(req_addr)));

  assert_count_nonzero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_count != '0));
endmodule

bind branch_sync_ctrl branch_sync_ctrl_chk #(.CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .branch_secure(branch_secure),
  .req_valid(req_valid), .req_ready(req_ready), .req_sync(req_sync),
  .req_count(req_count), .req_addr(req_addr)
);

// File: tb/tb_branch_sync_ctrl.sv
module tb_branch_sync_ctrl;
  logic        clk = 0, rst_n = 0, trace_en = 1, ret_valid = 0, ret_branch = 0;
  logic [31:0] branch_target = 0;
  logic        branch_secure = 0, lowpwr_dbg = 0, evt_in = 0, evt_en = 0, req_ready = 1;
  logic        req_valid, req_sync;
  logic [7:0]  req_count;
  logic [31:0] req_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_sync_ctrl dut (
    .clk(clk), .rst_n(rst_n), .trace_en(trace_en), .ret_valid(ret_valid),
    .ret_branch(ret_branch), .branch_target(branch_target), .branch_secure(branch_secure),
    .lowpwr_dbg(lowpwr_dbg), .evt_in(evt_in), .evt_en(evt_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_sync(req_sync), .req_count(req_count), .req_addr(req_addr)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic retire(int n);
    ret_valid = 1; ret_branch = 0;
    repeat (n) @(negedge clk);
    ret_valid = 0;
  endtask

  task automatic br(logic [31:0] a, logic sec);
    ret_valid = 1; ret_branch = 1; branch_target = a; branch_secure = sec;
    @(negedge clk);
    ret_valid = 0; ret_branch = 0; branch_secure = 0;
  endtask

  task automatic expect_req(string tag, logic sy, logic [7:0] cnt, logic [31:0] a);
    chk({tag, " valid"}, req_valid, 1);
    chk({tag, " sync"}, req_sync, sy);
    chk({tag, " count"}, req_count, cnt);
    chk({tag, " addr"}, req_addr, a);
    @(negedge clk);
  endtask

  task automatic expect_none(string tag);
    chk({tag, " no request"}, req_valid, 0);
    @(negedge clk);
  endtask

  task automatic t_reset_and_plain();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", req_valid, 0);
    rst_n = 1;
    br(32'h1000, 0); expect_req("R1 first branch", 1, 1, 32'h1000);
    retire(3);
    br(32'h2000, 0); expect_req("R2 plain after 3", 0, 4, 32'h2000);
    br(32'h2040, 0); expect_req("R2 plain back to back", 0, 1, 32'h2040);
  endtask

  task automatic t_enable();
    trace_en = 0;
    @(negedge clk);
    br(32'h3000, 0); expect_none("R3 disabled branch");
    retire(3);
    trace_en = 1;
    retire(2);
    br(32'h3100, 0); expect_req("R3 enable rise", 1, 3, 32'h3100);
    br(32'h3200, 0); expect_req("R3 after enable plain", 0, 1, 32'h3200);
  endtask

  task automatic t_lowpower();
    lowpwr_dbg = 1;
    repeat (3) @(negedge clk);
    lowpwr_dbg = 0;
    @(negedge clk);
    br(32'h4000, 0); expect_req("R4 exit sync", 1, 1, 32'h4000);
    br(32'h4010, 0); expect_req("R4 then plain", 0, 1, 32'h4010);
  endtask

  task automatic t_event();
    evt_en = 0; evt_in = 1; @(negedge clk); evt_in = 0;
    br(32'h5000, 0); expect_req("R5 event masked", 0, 1, 32'h5000);
    evt_en = 1; evt_in = 1; @(negedge clk); evt_in = 0;
    br(32'h5100, 0); expect_req("R5 event enabled", 1, 1, 32'h5100);
    evt_en = 0;
  endtask

  task automatic t_secure();
    br(32'h6000, 1); expect_none("R6 secure suppressed");
    retire(1);
    br(32'h6100, 0); expect_req("R6 after secure", 1, 3, 32'h6100);
  endtask

  task automatic t_collision();
    req_ready = 0;
    br(32'h7000, 0);
    chk("R7 first valid", req_valid, 1);
    br(32'h7100, 0);
    chk("R11 held count", req_count, 1);
    chk("R11 held addr", req_addr, 32'h7000);
    chk("R11 held sync", req_sync, 0);
    req_ready = 1;
    @(negedge clk);
    chk("R7 accepted", req_valid, 0);
    br(32'h7200, 0); expect_req("R7 after lost", 1, 2, 32'h7200);
  endtask

  task automatic t_overflow();
    retire(254);
    br(32'h8000, 0); expect_req("R8 count 255 plain", 0, 255, 32'h8000);
    retire(255);
    br(32'h8100, 0); expect_req("R8 overflow sync", 1, 1, 32'h8100);
  endtask

  task automatic t_sticky();
    req_ready = 0; evt_en = 1;
    evt_in = 1; @(negedge clk); evt_in = 0;
    br(32'h9000, 0);
    chk("R10 sync held", req_sync, 1);
    repeat (2) @(negedge clk);
    evt_in = 1; @(negedge clk); evt_in = 0;
    chk("R11 still valid", req_valid, 1);
    req_ready = 1; @(negedge clk);
    br(32'h9100, 0); expect_req("R10 late cause kept", 1, 1, 32'h9100);
    br(32'h9200, 0); expect_req("R10 cleared on accept", 0, 1, 32'h9200);
    evt_en = 0;
  endtask

  task automatic t_periodic();
    do_reset();
    for (int i = 1; i <= 254; i++) begin
      br(32'hA000 + i, 0);
      @(negedge clk);
    end
    br(32'hA0FF, 0); expect_req("R9 message 255 plain", 0, 1, 32'hA0FF);
    br(32'hA100, 0); expect_req("R9 periodic sync", 1, 1, 32'hA100);
  endtask

  initial begin
    @(negedge clk);
    t_reset_and_plain();
    t_enable();
    t_lowpower();
    t_event();
    t_secure();
    t_collision();
    t_overflow();
    t_sticky();
    t_periodic();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule